// File: doc/BRIEF.md
# Multirate FIFO with Pop-Before-Push Ordering

This block is a first-in, first-out store of data words on a single clock. Its write side and its read side step at different rates. One side steps on every clock, and the other steps once every `RATIO` clocks. The parameter `SLOW_POP` selects which side is the slow one. A free-running counter inside the block produces the enable strobe for the slow side. Requests on the slow side count only on the cycles that carry its strobe.

A successful read loads the oldest stored word into a registered output. The output keeps that word until the next successful read. When a read and a write land on the same step, the read is done first and the write second. A full store therefore still takes a write if a read happens on the same step.

Status is updated on every clock: the empty flag, the full flag and the entry count. A write on a full store and a read on an empty store can each raise a one-cycle error pulse. Each pulse can be enabled or suppressed by a response parameter. The depth need not be a power of two.

Top module: `mrate_fifo`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `count` is 0. `empty` is 1, `full` is 0, `dout` is 0, and `overflow` and `underflow` are 0.
- R2: A write step with `push`=1 and `count` < `DEPTH` stores `din`, and `count` rises by one at the next clock edge.
- R3: A read step with `pop`=1 and `count` > 0 removes the oldest word and loads it into `dout` at that clock edge. `dout` then holds that word until the next successful read. Words leave in the order they were written, including across the address wrap of a non-power-of-two depth.
- R4: When a write and a read land on the same step, the read is done first. If the store is full, the write is still accepted and `count` stays the same. If the store is empty, the read fails and the write is stored.
- R5: A write step on a full store (with no successful read on that step) is discarded. `count` and the stored words stay unchanged. If `OVF_RESP` is not `RESP_IGNORE`, `overflow` is 1 for exactly the one cycle after that edge.
- R6: A read step on an empty store leaves `dout` and `count` unchanged. If `UNF_RESP` is not `RESP_IGNORE`, `underflow` is 1 for exactly the one cycle after that edge.
- R7: When a response parameter is `RESP_IGNORE`, the matching pulse output stays 0 under all stimulus.
- R8: `empty` is 1 exactly when `count` is 0, and `full` is 1 exactly when `count` equals `DEPTH`. All three are updated on every clock.
- R9: The slow side steps once every `RATIO` clocks, and the fast side steps on every clock. The first slow step falls in the first clock cycle after reset is released. `SLOW_POP`=1 makes the read side slow, and `SLOW_POP`=0 makes the write side slow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W | Word to write |
| push | input | 1 | Write request, taken on write-side steps |
| pop | input | 1 | Read request, taken on read-side steps |
| dout | output | DATA_W | Last word read, held |
| empty | output | 1 | Store holds no words |
| full | output | 1 | Store holds DEPTH words |
| count | output | $clog2(DEPTH+1) | Number of stored words |
| overflow | output | 1 | One-cycle pulse after a rejected write |
| underflow | output | 1 | One-cycle pulse after a read on an empty store |

## Verification
A vector table at equal rates runs through four kinds of step:
- Lone writes and lone reads, which separate ordering faults from counting faults.
- A combined request while data is stored, which shows whether both operations happen.
- Reads on an empty store, which show whether `dout` is wrongly disturbed.
- A combined request on an empty store, which shows whether the read is really ordered before the write.

A directed fill to the depth of ten, followed by a combined request at full, tells pop-first ordering apart from push-first ordering. The drain that follows checks ordering across the non-power-of-two wrap. A second instance has a slow write side, depth four and suppressed pulses. A write held high on it shows whether the strobe phase and period are right, and it confirms that suppressed responses stay silent.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

  typedef enum logic [1:0] {
    RESP_IGNORE = 2'd0,
    RESP_WARN   = 2'd1,
    RESP_ERROR  = 2'd2
  } resp_e;

  typedef struct packed {
    logic do_push;
    logic do_pop;
    logic bad_push;
    logic bad_pop;
  } step_t;

  function automatic logic resp_active(input resp_e r);
    return r != RESP_IGNORE;
  endfunction

endpackage

// File: rtl/mrf_step_gen.sv
module mrf_step_gen #(
  parameter int RATIO = 1
) (
  input  logic clk,
  input  logic rst,
  output logic strobe
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (phase == CW'(RATIO - 1)) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign strobe = (phase == '0);
endmodule

// File: rtl/mrf_ram.sv
module mrf_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 10,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // read-first output register: same-address write returns the old word
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/mrf_ctrl.sv
module mrf_ctrl
  import mrf_pkg::*;
#(
  parameter int    DEPTH    = 10,
  parameter resp_e OVF_RESP = RESP_WARN,
  parameter resp_e UNF_RESP = RESP_WARN,
  localparam int   AW       = $clog2(DEPTH),
  localparam int   CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_step,
  input  logic             pop_step,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full,
  output logic             overflow,
  output logic             underflow
);
  localparam logic OVF_ON = resp_active(OVF_RESP);
  localparam logic UNF_ON = resp_active(UNF_RESP);

  step_t            st;
  logic [CNT_W-1:0] count_nxt;
  logic [AW-1:0]    wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    st.do_pop   = pop_step && (count != '0);
    st.do_push  = push_step && ((count != CNT_W'(DEPTH)) || st.do_pop);
    st.bad_push = push_step && !st.do_push;
    st.bad_pop  = pop_step && !st.do_pop;
    count_nxt   = count;
    if (st.do_push && !st.do_pop) begin
      count_nxt = count + 1'b1;
    end else if (st.do_pop && !st.do_push) begin
      count_nxt = count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      empty     <= 1'b1;
      full      <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (st.do_push) wptr <= bump(wptr);
      if (st.do_pop)  rptr <= bump(rptr);
      count     <= count_nxt;
      empty     <= (count_nxt == '0);
      full      <= (count_nxt == CNT_W'(DEPTH));
      overflow  <= OVF_ON && st.bad_push;
      underflow <= UNF_ON && st.bad_pop;
    end
  end

  assign wr_en   = st.do_push;
  assign wr_addr = wptr;
  assign rd_en   = st.do_pop;
  assign rd_addr = rptr;
endmodule

// File: rtl/mrate_fifo.sv
module mrate_fifo
  import mrf_pkg::*;
#(
  parameter int    DATA_W   = 8,
  parameter int    DEPTH    = 10,
  parameter int    RATIO    = 1,
  parameter bit    SLOW_POP = 1'b1,
  parameter resp_e OVF_RESP = RESP_WARN,
  parameter resp_e UNF_RESP = RESP_WARN,
  localparam int   AW       = $clog2(DEPTH),
  localparam int   CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              push,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  count,
  output logic              overflow,
  output logic              underflow
);
  logic          slow_stb, push_en, pop_en;
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;

  mrf_step_gen #(.RATIO(RATIO)) u_step (
    .clk    (clk),
    .rst    (rst),
    .strobe (slow_stb)
  );

  generate
    if (SLOW_POP) begin : g_pop_slow
      assign pop_en  = slow_stb;
      assign push_en = 1'b1;
    end else begin : g_push_slow
      assign pop_en  = 1'b1;
      assign push_en = slow_stb;
    end
  endgenerate

  mrf_ctrl #(
    .DEPTH    (DEPTH),
    .OVF_RESP (OVF_RESP),
    .UNF_RESP (UNF_RESP)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .push_step (push && push_en),
    .pop_step  (pop && pop_en),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .count     (count),
    .empty     (empty),
    .full      (full),
    .overflow  (overflow),
    .underflow (underflow)
  );

  mrf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (din),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (dout)
  );
endmodule

// File: rtl/mrf_chk.sv
module mrf_chk
  import mrf_pkg::*;
#(
  parameter int    DATA_W   = 8,
  parameter int    DEPTH    = 10,
  parameter resp_e OVF_RESP = RESP_WARN,
  parameter resp_e UNF_RESP = RESP_WARN,
  localparam int   CNT_W    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              push,
  input logic              pop,
  input logic [DATA_W-1:0] dout,
  input logic              empty,
  input logic              full,
  input logic [CNT_W-1:0]  count,
  input logic              overflow,
  input logic              underflow
);
  logic pv = 1'b0;
  always_ff @(posedge clk) pv <= 1'b1;

  assert_empty_match_R8: assert property (@(posedge clk) disable iff (rst)
    empty == (count == '0));

  assert_full_match_R8: assert property (@(posedge clk) disable iff (rst)
    full == (count == CNT_W'(DEPTH)));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst || !pv)
    (count > $past(count)) |-> (count == $past(count) + 1'b1));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst || !pv)
    overflow |-> ($past(count) == CNT_W'(DEPTH) && $past(push) && !$past(pop)));

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst || !pv)
    underflow |-> ($past(count) == '0 && $past(pop)));

  assert_dout_hold_R3: assert property (@(posedge clk) disable iff (rst || !pv)
    (dout != $past(dout)) |-> ($past(count) != '0 && $past(pop)));

  assert_ovf_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (OVF_RESP == RESP_IGNORE) |-> !overflow);

  assert_unf_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (UNF_RESP == RESP_IGNORE) |-> !underflow);
endmodule

bind mrate_fifo mrf_chk #(
  .DATA_W   (DATA_W),
  .DEPTH    (DEPTH),
  .OVF_RESP (OVF_RESP),
  .UNF_RESP (UNF_RESP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .push      (push),
  .pop       (pop),
  .dout      (dout),
  .empty     (empty),
  .full      (full),
  .count     (count),
  .overflow  (overflow),
  .underflow (underflow)
);

// File: tb/mrate_fifo_test.sv
`timescale 1ns/1ps
module mrate_fifo_test;
  import mrf_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1, push = 1'b0, pop = 1'b0;
  logic [7:0] din = '0, dout;
  logic       empty, full, ovf, unf;
  logic [3:0] count;

  logic       rst2 = 1'b1, push2 = 1'b0, pop2 = 1'b0;
  logic [7:0] din2 = '0, dout2;
  logic       empty2, full2, ovf2, unf2;
  logic [2:0] count2;

  int total = 0, bad = 0;

  mrate_fifo uut (
    .clk(clk), .rst(rst), .din(din), .push(push), .pop(pop), .dout(dout),
    .empty(empty), .full(full), .count(count), .overflow(ovf), .underflow(unf)
  );

  mrate_fifo #(
    .DATA_W(8), .DEPTH(4), .RATIO(2), .SLOW_POP(1'b0),
    .OVF_RESP(RESP_IGNORE), .UNF_RESP(RESP_IGNORE)
  ) uut_slowin (
    .clk(clk), .rst(rst2), .din(din2), .push(push2), .pop(pop2), .dout(dout2),
    .empty(empty2), .full(full2), .count(count2), .overflow(ovf2), .underflow(unf2)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic pu, input logic po, input logic [7:0] d);
    push = pu; pop = po; din = d;
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
  endtask

  typedef struct packed {
    logic       pu;
    logic       po;
    logic [7:0] d;
    logic [3:0] cnt;
    logic [7:0] q;
    logic       ov;
    logic       un;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1'b0, 1'b1, 8'h00, 4'd0, 8'h00, 1'b0, 1'b1},
    '{1'b1, 1'b0, 8'h11, 4'd1, 8'h00, 1'b0, 1'b0},
    '{1'b1, 1'b0, 8'h22, 4'd2, 8'h00, 1'b0, 1'b0},
    '{1'b1, 1'b0, 8'h33, 4'd3, 8'h00, 1'b0, 1'b0},
    '{1'b0, 1'b0, 8'h00, 4'd3, 8'h00, 1'b0, 1'b0},
    '{1'b0, 1'b1, 8'h00, 4'd2, 8'h11, 1'b0, 1'b0},
    '{1'b0, 1'b0, 8'h00, 4'd2, 8'h11, 1'b0, 1'b0},
    '{1'b1, 1'b1, 8'h44, 4'd2, 8'h22, 1'b0, 1'b0},
    '{1'b0, 1'b1, 8'h00, 4'd1, 8'h33, 1'b0, 1'b0},
    '{1'b0, 1'b1, 8'h00, 4'd0, 8'h44, 1'b0, 1'b0},
    '{1'b0, 1'b1, 8'h00, 4'd0, 8'h44, 1'b0, 1'b1},
    '{1'b1, 1'b1, 8'h55, 4'd1, 8'h44, 1'b0, 1'b1},
    '{1'b0, 1'b1, 8'h00, 4'd0, 8'h55, 1'b0, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "count in reset", int'(count), 0);
    chk("R1", "empty in reset", int'(empty), 1);
    rst = 1'b0;
    chk("R1", "dout after release", int'(dout), 0);
    chk("R1", "full after release", int'(full), 0);
    chk("R1", "pulses after release", int'({ovf, unf}), 0);

    // R2 R3 R4 R6 R8: vector walk at equal rates
    foreach (VEC[i]) begin
      step(VEC[i].pu, VEC[i].po, VEC[i].d);
      chk("R2", $sformatf("row%0d count", i), int'(count), int'(VEC[i].cnt));
      chk("R3", $sformatf("row%0d dout", i), int'(dout), int'(VEC[i].q));
      chk("R5", $sformatf("row%0d overflow", i), int'(ovf), int'(VEC[i].ov));
      chk("R6", $sformatf("row%0d underflow", i), int'(unf), int'(VEC[i].un));
      chk("R8", $sformatf("row%0d empty", i), int'(empty), int'(VEC[i].cnt == 0));
      chk("R8", $sformatf("row%0d full", i), int'(full), 0);
    end

    // fill to depth 10
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 8'hA0 + 8'(i));
    chk("R8", "full at depth", int'(full), 1);
    chk("R2", "count at depth", int'(count), 10);
    chk("R8", "not empty at depth", int'(empty), 0);

    // R5: write on full is dropped, one-cycle pulse
    step(1'b1, 1'b0, 8'hEE);
    chk("R5", "overflow pulse", int'(ovf), 1);
    chk("R5", "count after drop", int'(count), 10);
    step(1'b0, 1'b0, 8'h00);
    chk("R5", "overflow single cycle", int'(ovf), 0);

    // R4: combined request on full
    step(1'b1, 1'b1, 8'hBB);
    chk("R4", "count full push+pop", int'(count), 10);
    chk("R4", "dout full push+pop", int'(dout), 8'hA0);
    chk("R4", "no overflow on push+pop", int'(ovf), 0);

    // R3: drain across the wrap
    for (int i = 1; i < 10; i++) begin
      step(1'b0, 1'b1, 8'h00);
      chk("R3", $sformatf("drain %0d", i), int'(dout), 8'hA0 + i);
    end
    step(1'b0, 1'b1, 8'h00);
    chk("R3", "drain last", int'(dout), 8'hBB);
    chk("R8", "empty after drain", int'(empty), 1);

    // R1: reset in mid-operation
    step(1'b1, 1'b0, 8'h77);
    step(1'b0, 1'b1, 8'h00);
    step(1'b1, 1'b0, 8'h78);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1", "count after mid reset", int'(count), 0);
    chk("R1", "dout after mid reset", int'(dout), 0);
    chk("R1", "empty after mid reset", int'(empty), 1);

    // R9 R7: slow write side, ratio 2, depth 4, responses ignored
    rst2 = 1'b0; push2 = 1'b1; din2 = 8'h05;
    for (int e = 1; e <= 12; e++) begin
      @(negedge clk);
      chk("R9", $sformatf("slow write edge %0d", e), int'(count2),
          ((e + 1) / 2 > 4) ? 4 : (e + 1) / 2);
      chk("R7", $sformatf("overflow silent edge %0d", e), int'(ovf2), 0);
    end
    chk("R8", "slow instance full", int'(full2), 1);
    push2 = 1'b0; pop2 = 1'b1;
    @(negedge clk);
    chk("R9", "fast read each cycle", int'(count2), 3);
    chk("R3", "slow instance dout", int'(dout2), 5);
    for (int e = 0; e < 5; e++) begin
      @(negedge clk);
      chk("R7", $sformatf("underflow silent %0d", e), int'(unf2), 0);
    end
    chk("R6", "slow instance empty count", int'(count2), 0);
    pop2 = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule